// File: doc/BRIEF.md
# Glitch-Free Clock Switch Sequencer

This block picks the system clock from one of four oscillator sources, chosen by a two-bit select code. When the code changes, the clock that is driving the output keeps running until the chosen source says it is ready. The block then turns the old source off and the new one on, each in its own clock domain. Between the two steps the output is held low, so every high and low phase of the output is at least as long as the shorter half-period of the two sources.

A free-running control clock runs a small sequencer. The sequencer synchronises the per-source ready flags and the gate acknowledges. Each source has a gate cell in its own domain. The cell passes the enable request through two flip-flops, so it needs two rising edges of that source. It then changes the gate on the next falling edge, while that clock is low. Two sources come from one internal high-frequency root. A switch between those two does not wait for a ready flag. A select change made during a switch is held, and that switch starts as soon as the current one ends. Status outputs report the active source, and whether the external crystal or the internal root is the active and stable clock.

Top module: `clksw_top`

## Requirements
- R1: After reset the block is idle (busy=0), act_src=2, and sys_clk runs at the period of source 2.
- R2: With the target source ready, a select change that differs from act_src raises busy on the next control-clock edge. After the switch, act_src equals the new code and sys_clk runs at that source's period.
- R3: While the target source's ready flag is low, busy stays high, act_src does not change, and sys_clk keeps the old source's period.
- R4: No high or low phase of sys_clk is shorter than the smaller half-period of the old and new sources. At no time are two source gates enabled together.
- R5: Before the first high phase from the new source, sys_clk stays low for at least two periods of the new source.
- R6: A switch between sources 2 and 3, which share the internal root, completes even while the target's ready flag is low.
- R7: busy stays high from the select change until the switch completes. When busy falls, act_src equals the select code of the previous control cycle.
- R8: A select change made while busy is queued. busy does not drop between the two switches, and act_src ends at the latest code.
- R9: ext_ok is 1 only when act_src=0 and source 0's ready flag is high. hfi_ok is 1 only when act_src is 2 or 3 and that source's ready flag is high.
- R10: A select code equal to act_src starts no switch, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Active-high reset, synchronous to clk, resynchronised in each source domain |
| src_clk | input | 4 | Source clocks, one bit per source |
| src_rdy | input | 4 | Per-source ready flags, asynchronous |
| sel | input | 2 | Requested source code, synchronous to clk |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| busy | output | 1 | Switch in progress |
| act_src | output | 2 | Code of the source currently driving sys_clk |
| ext_ok | output | 1 | External crystal (source 0) active and ready |
| hfi_ok | output | 1 | Internal root source (2 or 3) active and ready |

## Verification
The bench watches every edge of sys_clk. It flags any phase shorter than the smaller of the two source half-periods, which is how a gate that changed while its clock was high, or a new gate opened before the old one closed, would show up. It keeps the target's ready flag low for a long time and checks that the old period continues. A sequencer that did not wait for ready would switch to a dead source. It checks that the low hold spans at least two new-clock periods, which a missing synchroniser stage would shorten. It also checks that a switch between the two internal sources ignores the ready flag, and that a select change made mid-switch neither drops busy early nor is lost.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        SW_IDLE     = 2'd0,
        SW_WAIT_RDY = 2'd1,
        SW_OLD_OFF  = 2'd2,
        SW_NEW_ON   = 2'd3
    } sw_state_e;

    // Two sources share a root when both are marked in the mask.
    function automatic logic same_root(input logic [31:0] mask,
                                       input int unsigned a,
                                       input int unsigned b);
        return mask[a] & mask[b];
    endfunction

    function automatic logic [31:0] one_at(input int unsigned idx);
        return 32'd1 << idx;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
    parameter int unsigned STAGES = 2,
    parameter bit          RST_ON = 1'b0
) (
    input  logic clk_g,
    input  logic rst,
    input  logic en_req,
    output logic gclk,
    output logic en_q
);
    logic rst_g;
    logic req_s;
    logic en_n;

    // reset brought into this source's domain
    clksw_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_rst (
        .clk(clk_g), .rst(1'b0), .d(rst), .q(rst_g)
    );

    // enable request: consumes STAGES rising edges of this clock
    clksw_sync #(.W(1), .STAGES(STAGES), .RST_VAL(RST_ON)) u_req (
        .clk(clk_g), .rst(rst_g), .d(en_req), .q(req_s)
    );

    // gate changes only while this clock is low
    always_ff @(negedge clk_g) begin
        if (rst_g) en_n <= RST_ON;
        else       en_n <= req_s;
    end

    assign gclk = clk_g & en_n;
    assign en_q = en_n;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int unsigned  N_SRC    = 4,
    parameter int unsigned  SEL_W    = 2,
    parameter int unsigned  RST_SRC  = 2,
    parameter logic [N_SRC-1:0] INT_MASK = 4'b1100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] rdy_s,
    input  logic [N_SRC-1:0] ack_s,
    output logic [N_SRC-1:0] en_req,
    output logic             busy,
    output logic [SEL_W-1:0] cur
);
    localparam logic [N_SRC-1:0] RST_ONEHOT = N_SRC'(one_at(RST_SRC));

    typedef struct packed {
        sw_state_e        st;
        logic [SEL_W-1:0] cur;
        logic [SEL_W-1:0] tgt;
    } sw_ctx_t;

    sw_ctx_t          q, nx;
    logic [N_SRC-1:0] req_q, req_n;
    logic             sel_ok;

    assign sel_ok = (32'(sel) < N_SRC);

    always_comb begin
        nx    = q;
        req_n = req_q;
        unique case (q.st)
            SW_IDLE: begin
                if (sel_ok && sel != q.cur) begin
                    nx.tgt = sel;
                    if (same_root(32'(INT_MASK), q.cur, sel)) begin
                        req_n[q.cur] = 1'b0;
                        nx.st        = SW_OLD_OFF;
                    end else begin
                        nx.st = SW_WAIT_RDY;
                    end
                end
            end
            SW_WAIT_RDY: begin
                if (rdy_s[q.tgt]) begin
                    req_n[q.cur] = 1'b0;
                    nx.st        = SW_OLD_OFF;
                end
            end
            SW_OLD_OFF: begin
                if (!ack_s[q.cur]) begin
                    req_n[q.tgt] = 1'b1;
                    nx.st        = SW_NEW_ON;
                end
            end
            SW_NEW_ON: begin
                if (ack_s[q.tgt]) begin
                    nx.cur = q.tgt;
                    if (sel_ok && sel != q.tgt) begin
                        nx.tgt = sel;
                        if (same_root(32'(INT_MASK), q.tgt, sel)) begin
                            req_n[q.tgt] = 1'b0;
                            nx.st        = SW_OLD_OFF;
                        end else begin
                            nx.st = SW_WAIT_RDY;
                        end
                    end else begin
                        nx.st = SW_IDLE;
                    end
                end
            end
            default: nx.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= SW_IDLE;
            q.cur <= SEL_W'(RST_SRC);
            q.tgt <= SEL_W'(RST_SRC);
            req_q <= RST_ONEHOT;
        end else begin
            q     <= nx;
            req_q <= req_n;
        end
    end

    assign en_req = req_q;
    assign busy   = (q.st != SW_IDLE);
    assign cur    = q.cur;
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int unsigned      N_SRC    = 4,
    parameter int unsigned      SYNC_STG = 2,
    parameter int unsigned      RST_SRC  = 2,
    parameter int unsigned      EXT_SRC  = 0,
    parameter logic [N_SRC-1:0] INT_MASK = 4'b1100,
    localparam int unsigned     SEL_W    = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_clk,
    input  logic [N_SRC-1:0] src_rdy,
    input  logic [SEL_W-1:0] sel,
    output logic             sys_clk,
    output logic             busy,
    output logic [SEL_W-1:0] act_src,
    output logic             ext_ok,
    output logic             hfi_ok
);
    localparam logic [N_SRC-1:0] RST_ONEHOT = N_SRC'(one_at(RST_SRC));

    logic [N_SRC-1:0] rdy_s;
    logic [N_SRC-1:0] ack_s;
    logic [N_SRC-1:0] en_req;
    logic [N_SRC-1:0] gate_en;
    logic [N_SRC-1:0] gclk_v;

    clksw_sync #(.W(N_SRC), .STAGES(SYNC_STG), .RST_VAL('0)) u_rdy_sync (
        .clk(clk), .rst(rst), .d(src_rdy), .q(rdy_s)
    );

    clksw_sync #(.W(N_SRC), .STAGES(SYNC_STG), .RST_VAL(RST_ONEHOT)) u_ack_sync (
        .clk(clk), .rst(rst), .d(gate_en), .q(ack_s)
    );

    clksw_ctrl #(
        .N_SRC(N_SRC), .SEL_W(SEL_W), .RST_SRC(RST_SRC), .INT_MASK(INT_MASK)
    ) u_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .rdy_s(rdy_s), .ack_s(ack_s),
        .en_req(en_req), .busy(busy), .cur(act_src)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        clksw_gate #(.STAGES(SYNC_STG), .RST_ON(i == RST_SRC)) u_gate (
            .clk_g(src_clk[i]), .rst(rst), .en_req(en_req[i]),
            .gclk(gclk_v[i]), .en_q(gate_en[i])
        );
    end

    assign sys_clk = |gclk_v;
    assign ext_ok  = (32'(act_src) == EXT_SRC) && rdy_s[EXT_SRC];
    assign hfi_ok  = INT_MASK[act_src] && rdy_s[act_src];
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
    parameter int unsigned      N_SRC    = 4,
    parameter int unsigned      SEL_W    = 2,
    parameter int unsigned      EXT_SRC  = 0,
    parameter logic [N_SRC-1:0] INT_MASK = 4'b1100
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] sel,
    input logic             busy,
    input logic [SEL_W-1:0] act_src,
    input logic             ext_ok,
    input logic             hfi_ok,
    input logic [N_SRC-1:0] gate_en
);
    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && sel != act_src) |=> busy);

    assert_src_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_src) |-> $past(busy));

    assert_one_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_en));

    assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (act_src == $past(sel)));

    assert_ext_flag_R9: assert property (@(posedge clk) disable iff (rst)
        ext_ok |-> (32'(act_src) == EXT_SRC));

    assert_int_flag_R9: assert property (@(posedge clk) disable iff (rst)
        hfi_ok |-> INT_MASK[act_src]);

    assert_no_switch_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && sel == act_src) |=> !busy);
endmodule

bind clksw_top clksw_chk #(
    .N_SRC(N_SRC), .SEL_W(SEL_W), .EXT_SRC(EXT_SRC), .INT_MASK(INT_MASK)
) chk_i (
    .clk(clk), .rst(rst), .sel(sel), .busy(busy), .act_src(act_src),
    .ext_ok(ext_ok), .hfi_ok(hfi_ok), .gate_en(gate_en)
);

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_clk = '0;
    logic [3:0] src_rdy = 4'b1101;
    logic [1:0] sel = 2'd2;
    logic       sys_clk, busy, ext_ok, hfi_ok;
    logic [1:0] act_src;

    int n_tests = 0;
    int n_fail  = 0;

    // half-periods in ns of the four sources
    real hp [4] = '{10.0, 30.0, 5.0, 7.0};

    always #4    clk        = ~clk;
    always #10   src_clk[0] = ~src_clk[0];
    always #30   src_clk[1] = ~src_clk[1];
    always #5    src_clk[2] = ~src_clk[2];
    always #7    src_clk[3] = ~src_clk[3];

    clksw_top dut_i (
        .clk(clk), .rst(rst), .src_clk(src_clk), .src_rdy(src_rdy), .sel(sel),
        .sys_clk(sys_clk), .busy(busy), .act_src(act_src),
        .ext_ok(ext_ok), .hfi_ok(hfi_ok)
    );

    // phase monitor on sys_clk
    realtime t_last = 0.0;
    real     min_hp = 5.0;
    real     max_low = 0.0;
    int      runts = 0;
    bit      mon_en = 1'b0;

    always @(sys_clk) begin
        real ph;
        ph = $realtime - t_last;
        if (mon_en) begin
            if (ph < min_hp - 0.001) runts++;
            if (sys_clk && ph > max_low) max_low = ph;
        end
        t_last = $realtime;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic period_ps(output longint p);
        realtime t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = longint'(($realtime - t0) * 1000.0);
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (!busy) begin ok = 1'b1; break; end
        end
    endtask

    // switch to source 'to'; if hold_rdy, keep its ready low for a while
    task automatic do_switch(input int to, input bit hold_rdy, input string rq);
        int     from;
        bit     ok;
        longint p;
        from    = int'(act_src);
        min_hp  = (hp[from] < hp[to]) ? hp[from] : hp[to];
        max_low = 0.0;
        runts   = 0;
        if (hold_rdy) src_rdy[to] = 1'b0;
        @(negedge clk);
        sel = 2'(to);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b1, rq, "busy after select change (R7)", busy, 1);
        if (hold_rdy) begin
            repeat (300) @(negedge clk);
            chk(busy == 1'b1, "R3", "busy while not ready", busy, 1);
            chk(int'(act_src) == from, "R3", "act_src while not ready", act_src, from);
            period_ps(p);
            chk(p == longint'(hp[from] * 2000.0), "R3", "old period kept", p,
                longint'(hp[from] * 2000.0));
            src_rdy[to] = 1'b1;
        end
        wait_idle(ok);
        chk(ok, rq, "switch completes", ok, 1);
        chk(int'(act_src) == to, rq, "act_src after switch", act_src, to);
        period_ps(p);
        chk(p == longint'(hp[to] * 2000.0), rq, "new period", p, longint'(hp[to] * 2000.0));
        chk(runts == 0, "R4", "runt phases", runts, 0);
        chk(max_low >= hp[to] * 4.0 - 0.001, "R5", "low hold ps",
            longint'(max_low * 1000.0), longint'(hp[to] * 4000.0));
    endtask

    task automatic t_reset();
        longint p;
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(act_src == 2'd2, "R1", "act_src after reset", act_src, 2);
        period_ps(p);
        chk(p == 64'd10000, "R1", "reset period", p, 10000);
        chk(hfi_ok == 1'b1, "R9", "hfi_ok on source 2", hfi_ok, 1);
        chk(ext_ok == 1'b0, "R9", "ext_ok on source 2", ext_ok, 0);
    endtask

    task automatic t_same_sel();
        int seen;
        seen = 0;
        sel = act_src;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, "R10", "busy cycles on unchanged code", seen, 0);
        chk(act_src == 2'd2, "R10", "act_src unchanged", act_src, 2);
    endtask

    task automatic t_to_ext();
        do_switch(0, 1'b0, "R2");
        repeat (6) @(negedge clk);
        chk(ext_ok == 1'b1, "R9", "ext_ok on source 0", ext_ok, 1);
        chk(hfi_ok == 1'b0, "R9", "hfi_ok on source 0", hfi_ok, 0);
    endtask

    task automatic t_wait_ready();
        do_switch(1, 1'b1, "R2");
    endtask

    task automatic t_shared();
        do_switch(2, 1'b0, "R2");
        src_rdy[3] = 1'b0;
        do_switch(3, 1'b0, "R6");
        repeat (6) @(negedge clk);
        chk(hfi_ok == 1'b0, "R9", "hfi_ok with ready low", hfi_ok, 0);
        src_rdy[3] = 1'b1;
        repeat (6) @(negedge clk);
        chk(hfi_ok == 1'b1, "R9", "hfi_ok with ready high", hfi_ok, 1);
    endtask

    task automatic t_queue();
        int     drops;
        bit     done;
        longint p;
        drops  = 0;
        done   = 1'b0;
        min_hp = 7.0;
        runts  = 0;
        @(negedge clk);
        sel = 2'd1;
        repeat (4) @(negedge clk);
        sel = 2'd0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!busy) begin
                if (act_src == 2'd0) begin done = 1'b1; break; end
                drops++;
            end
        end
        chk(done, "R8", "queued switch finished", done, 1);
        chk(drops == 0, "R8", "idle cycles between switches", drops, 0);
        chk(act_src == 2'd0, "R8", "final act_src", act_src, 0);
        period_ps(p);
        chk(p == 64'd20000, "R8", "final period", p, 20000);
        chk(runts == 0, "R4", "runt phases in queue", runts, 0);
    endtask

    task automatic t_ext_lost();
        src_rdy[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk(ext_ok == 1'b0, "R9", "ext_ok with ready low", ext_ok, 0);
        src_rdy[0] = 1'b1;
        repeat (6) @(negedge clk);
        chk(ext_ok == 1'b1, "R9", "ext_ok restored", ext_ok, 1);
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (40) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        mon_en = 1'b1;
        t_reset();
        t_same_sel();
        t_to_ext();
        t_wait_ready();
        t_shared();
        t_queue();
        t_ext_lost();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule